// File: doc/BRIEF.md
# Debug State Save/Restore Sequencer

This block lets software carry a bank of debug configuration registers across a core power-down through one data port. Once the lock input is set, software reads the port once to learn how many words make up the image. It then either reads that many words in a row (save) or writes that many words in a row (restore). The block walks an internal slot counter, reads the bank in parallel on a save, and raises a one-hot write enable toward the bank on a restore.

The slot order is fixed. Slot 0 is the watchpoint fault address. Next come the breakpoint value/control pairs, then the watchpoint value/control pairs, then vector catch. After that come the two cache/MMU control words, and last the transmit and receive transfer registers. Lane k of the parallel bank bus carries slot k. A save of a transfer register whose full flag is clear yields zero. Any misuse sets a sticky error flag and freezes the sequence until the lock is set again. Misuse means a mixed direction, an access past the count, a write before the count read, a read and write in the same cycle, or a lock drop during a restore.

The states are UNLOCKED, WAIT_COUNT, WAIT_DIR, SAVE, RESTORE, DONE and FAULT. The transitions are:
- UNLOCKED→WAIT_COUNT when the lock rises.
- WAIT_COUNT→WAIT_DIR on the count read.
- WAIT_DIR→SAVE on a read, and WAIT_DIR→RESTORE on a write.
- SAVE or RESTORE→DONE on the final slot.
- Any locked state→FAULT on misuse.
- Any state→UNLOCKED when the lock falls.

Top module: `dbgstate_seq`

## Requirements
- R1: After reset, rdata_o is 0, seq_err_o is 0 and bank_we_o is all zero.
- R2: While lock_i is 0 or core_pwr_i is 0, a read returns 0 on rdata_o, a write raises no bank_we_o bit, and the sequence position does not move.
- R3: The first read after the lock is set returns the slot count, 1 + 2*NUM_BP + 2*NUM_WP + 5, on rdata_o in the cycle after the read strobe.
- R4: In a save, the k-th data read returns the word on lane k of bank_q_i in the cycle after its strobe, with no wait state, for k from 0 to count-1.
- R5: In a restore, the k-th data write raises only bank_we_o[k] in the cycle of the strobe, with bank_wd_o equal to wdata_i.
- R6: A save read of slot count-2 (transmit) returns 0 when tx_full_i is 0. A save read of slot count-1 (receive) returns 0 when rx_full_i is 0. When the flag is 1, the lane value is returned.
- R7: An access whose direction differs from the first data access, or a read and a write in the same cycle, sets seq_err_o. That access and every later one return 0 or write nothing until relock.
- R8: An access after all slots have been transferred sets seq_err_o and is ignored.
- R9: Clearing the lock during a restore sets seq_err_o, and slots not yet written keep their values. Clearing it during a save or after a completed sequence leaves seq_err_o at 0.
- R10: Setting the lock again clears seq_err_o and restarts the sequence, so the next read returns the count once more.
- R11: A write before the count read sets seq_err_o and writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lock_i | input | 1 | Save/restore lock |
| core_pwr_i | input | 1 | Core domain powered |
| rd_i | input | 1 | Read strobe of the data port |
| wr_i | input | 1 | Write strobe of the data port |
| wdata_i | input | DW | Write data |
| rdata_o | output | DW | Read data, valid the cycle after rd_i |
| seq_err_o | output | 1 | Sticky sequence error |
| tx_full_i | input | 1 | Transmit transfer register holds data |
| rx_full_i | input | 1 | Receive transfer register holds data |
| bank_q_i | input | NREG*DW | Current bank contents, lane k is slot k |
| bank_we_o | output | NREG | One-hot bank write enable |
| bank_wd_o | output | DW | Bank write data |

## Verification
A slot counter that is off by one shows at once. The next save read returns a neighbouring lane's pattern, or a restore write lands on the wrong bank_we_o bit, in the very cycle of the access. A wrong state shows within one access: a missing count word, an error flag that fails to rise or fall, or a bank slot altered by an access that should have been refused. Because every lane carries a distinct pattern, each misrouted word can be traced to its slot.

// File: rtl/dbgstate_pkg.sv
package dbgstate_pkg;

    typedef enum logic [2:0] {
        ST_UNLOCKED,
        ST_WAIT_COUNT,
        ST_WAIT_DIR,
        ST_SAVE,
        ST_RESTORE,
        ST_DONE,
        ST_FAULT
    } seq_state_e;

    // slots: fault address, bp pairs, wp pairs, vector catch, two control words, tx, rx
    function automatic int slot_count(input int nbp, input int nwp);
        return 1 + 2 * nbp + 2 * nwp + 5;
    endfunction

endpackage

// File: rtl/dbgstate_fsm.sv
module dbgstate_fsm
    import dbgstate_pkg::*;
#(
    parameter int NREG  = 14,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lock_i,
    input  logic             pwr_i,
    input  logic             rd_i,
    input  logic             wr_i,
    output logic [IDX_W-1:0] idx_o,
    output logic             count_rd_o,
    output logic             bank_rd_o,
    output logic             bank_wr_o,
    output logic             err_o
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NREG - 1);
    localparam logic [IDX_W-1:0] NREG_IDX = IDX_W'(NREG);

    seq_state_e       state_q, state_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic             err_q, err_d;
    logic             rd_only, wr_only, any_acc;

    assign rd_only = pwr_i && rd_i && !wr_i;
    assign wr_only = pwr_i && wr_i && !rd_i;
    assign any_acc = pwr_i && (rd_i || wr_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_UNLOCKED;
            idx_q   <= '0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            err_q   <= err_d;
        end
    end

    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        err_d   = err_q;
        if (state_q == ST_UNLOCKED) begin
            if (lock_i) begin
                state_d = ST_WAIT_COUNT;
                idx_d   = '0;
                err_d   = 1'b0;
            end
        end else if (!lock_i) begin
            state_d = ST_UNLOCKED;
            if (state_q == ST_RESTORE) begin
                err_d = 1'b1;
            end
        end else if (any_acc) begin
            unique case (state_q)
                ST_WAIT_COUNT: begin
                    if (rd_only) begin
                        state_d = ST_WAIT_DIR;
                    end else begin
                        state_d = ST_FAULT;
                        err_d   = 1'b1;
                    end
                end
                ST_WAIT_DIR: begin
                    if (rd_only || wr_only) begin
                        idx_d = idx_q + 1'b1;
                        if (idx_q == LAST_IDX) begin
                            state_d = ST_DONE;
                        end else begin
                            state_d = rd_only ? ST_SAVE : ST_RESTORE;
                        end
                    end else begin
                        state_d = ST_FAULT;
                        err_d   = 1'b1;
                    end
                end
                ST_SAVE: begin
                    if (rd_only) begin
                        idx_d = idx_q + 1'b1;
                        if (idx_q == LAST_IDX) begin
                            state_d = ST_DONE;
                        end
                    end else begin
                        state_d = ST_FAULT;
                        err_d   = 1'b1;
                    end
                end
                ST_RESTORE: begin
                    if (wr_only) begin
                        idx_d = idx_q + 1'b1;
                        if (idx_q == LAST_IDX) begin
                            state_d = ST_DONE;
                        end
                    end else begin
                        state_d = ST_FAULT;
                        err_d   = 1'b1;
                    end
                end
                ST_DONE: begin
                    state_d = ST_FAULT;
                    err_d   = 1'b1;
                end
                ST_FAULT: begin
                    state_d = ST_FAULT;
                end
                ST_UNLOCKED: begin
                    state_d = ST_UNLOCKED;
                end
            endcase
        end
    end

    always_comb begin
        count_rd_o = 1'b0;
        bank_rd_o  = 1'b0;
        bank_wr_o  = 1'b0;
        if (lock_i) begin
            unique case (state_q)
                ST_WAIT_COUNT: count_rd_o = rd_only;
                ST_WAIT_DIR: begin
                    bank_rd_o = rd_only;
                    bank_wr_o = wr_only;
                end
                ST_SAVE:    bank_rd_o = rd_only;
                ST_RESTORE: bank_wr_o = wr_only;
                ST_UNLOCKED, ST_DONE, ST_FAULT: begin
                    count_rd_o = 1'b0;
                end
            endcase
        end
    end

    assign idx_o = idx_q;
    assign err_o = err_q;

    a_r8_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
        idx_q <= NREG_IDX);

    a_r9_lock_drop_restore: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RESTORE && !lock_i) |=> err_q);

    a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (err_q && state_q != ST_UNLOCKED) |=> err_q);

    a_r10_relock_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_UNLOCKED && lock_i) |=> (!err_q && state_q == ST_WAIT_COUNT));

endmodule

// File: rtl/dbgstate_rdmux.sv
module dbgstate_rdmux #(
    parameter int NREG  = 14,
    parameter int DW    = 32,
    parameter int IDX_W = 4
) (
    input  logic [NREG*DW-1:0] bank_q_i,
    input  logic [IDX_W-1:0]   sel_i,
    input  logic               tx_full_i,
    input  logic               rx_full_i,
    output logic [DW-1:0]      word_o
);

    localparam int TX_SLOT = NREG - 2;
    localparam int RX_SLOT = NREG - 1;

    logic [DW-1:0] lane [NREG];

    for (genvar k = 0; k < NREG; k++) begin : g_lane
        if (k == TX_SLOT) begin : g_tx
            assign lane[k] = tx_full_i ? bank_q_i[k*DW +: DW] : '0;
        end else if (k == RX_SLOT) begin : g_rx
            assign lane[k] = rx_full_i ? bank_q_i[k*DW +: DW] : '0;
        end else begin : g_plain
            assign lane[k] = bank_q_i[k*DW +: DW];
        end
    end

    always_comb begin
        word_o = '0;
        for (int k = 0; k < NREG; k++) begin
            if (sel_i == IDX_W'(k)) begin
                word_o = lane[k];
            end
        end
    end

endmodule

// File: rtl/dbgstate_wrdec.sv
module dbgstate_wrdec #(
    parameter int NREG  = 14,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [IDX_W-1:0] sel_i,
    output logic [NREG-1:0]  we_o
);

    for (genvar k = 0; k < NREG; k++) begin : g_we
        assign we_o[k] = wr_en_i && (sel_i == IDX_W'(k));
    end

    a_r5_we_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(we_o));

    a_r5_we_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |-> (we_o == '0));

endmodule

// File: rtl/dbgstate_seq.sv
module dbgstate_seq
    import dbgstate_pkg::*;
#(
    parameter int NUM_BP = 2,
    parameter int NUM_WP = 2,
    parameter int DW     = 32,
    parameter int NREG   = slot_count(NUM_BP, NUM_WP)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               lock_i,
    input  logic               core_pwr_i,
    input  logic               rd_i,
    input  logic               wr_i,
    input  logic [DW-1:0]      wdata_i,
    output logic [DW-1:0]      rdata_o,
    output logic               seq_err_o,
    input  logic               tx_full_i,
    input  logic               rx_full_i,
    input  logic [NREG*DW-1:0] bank_q_i,
    output logic [NREG-1:0]    bank_we_o,
    output logic [DW-1:0]      bank_wd_o
);

    localparam int IDX_W = $clog2(NREG + 1);
    localparam logic [DW-1:0] COUNT_WORD = DW'(NREG);

    logic [IDX_W-1:0] idx;
    logic             count_rd, bank_rd, bank_wr;
    logic [DW-1:0]    mux_word;
    logic [DW-1:0]    rdata_q;

    dbgstate_fsm #(.NREG(NREG), .IDX_W(IDX_W)) fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .lock_i     (lock_i),
        .pwr_i      (core_pwr_i),
        .rd_i       (rd_i),
        .wr_i       (wr_i),
        .idx_o      (idx),
        .count_rd_o (count_rd),
        .bank_rd_o  (bank_rd),
        .bank_wr_o  (bank_wr),
        .err_o      (seq_err_o)
    );

    dbgstate_rdmux #(.NREG(NREG), .DW(DW), .IDX_W(IDX_W)) rdmux_i (
        .bank_q_i  (bank_q_i),
        .sel_i     (idx),
        .tx_full_i (tx_full_i),
        .rx_full_i (rx_full_i),
        .word_o    (mux_word)
    );

    dbgstate_wrdec #(.NREG(NREG), .IDX_W(IDX_W)) wrdec_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en_i (bank_wr),
        .sel_i   (idx),
        .we_o    (bank_we_o)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (rd_i) begin
            if (count_rd) begin
                rdata_q <= COUNT_WORD;
            end else if (bank_rd) begin
                rdata_q <= mux_word;
            end else begin
                rdata_q <= '0;
            end
        end
    end

    assign rdata_o   = rdata_q;
    assign bank_wd_o = wdata_i;

    a_r2_no_write_when_closed: assert property (@(posedge clk) disable iff (!rst_n)
        !(lock_i && core_pwr_i) |-> (bank_we_o == '0));

    a_r2_zero_read_when_closed: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && !(lock_i && core_pwr_i)) |=> (rdata_o == '0));

    a_r3_count_word: assert property (@(posedge clk) disable iff (!rst_n)
        count_rd |=> (rdata_o == COUNT_WORD));

    a_r6_tx_empty_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_rd && idx == IDX_W'(NREG - 2) && !tx_full_i) |=> (rdata_o == '0));

    a_r6_rx_empty_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_rd && idx == IDX_W'(NREG - 1) && !rx_full_i) |=> (rdata_o == '0));

    a_r5_write_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_we_o != '0) |-> (wr_i && !rd_i));

endmodule

// File: tb/dbgstate_seq_tb.sv
module dbgstate_seq_tb_top;

    localparam int NBP  = 2;
    localparam int NWP  = 2;
    localparam int DW   = 32;
    localparam int NREG = 1 + 2 * NBP + 2 * NWP + 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lock = 1'b0, pwr = 1'b1, rd = 1'b0, wr = 1'b0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic err;
    logic txf = 1'b1, rxf = 1'b1;
    logic [NREG*DW-1:0] bank_flat;
    logic [NREG-1:0] we;
    logic [DW-1:0] wd;
    logic [DW-1:0] bank [NREG];

    int checks = 0;
    int errors = 0;
    logic [DW-1:0] got;

    always #2 clk = ~clk;

    dbgstate_seq #(.NUM_BP(NBP), .NUM_WP(NWP), .DW(DW)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .lock_i     (lock),
        .core_pwr_i (pwr),
        .rd_i       (rd),
        .wr_i       (wr),
        .wdata_i    (wdata),
        .rdata_o    (rdata),
        .seq_err_o  (err),
        .tx_full_i  (txf),
        .rx_full_i  (rxf),
        .bank_q_i   (bank_flat),
        .bank_we_o  (we),
        .bank_wd_o  (wd)
    );

    always_comb begin
        for (int k = 0; k < NREG; k++) bank_flat[k*DW +: DW] = bank[k];
    end

    always_ff @(posedge clk) begin
        for (int k = 0; k < NREG; k++) if (we[k]) bank[k] <= wd;
    end

    function automatic logic [DW-1:0] pat_a(input int k);
        return 32'hA500_0000 + 32'(k) * 32'h0001_0101;
    endfunction

    function automatic logic [DW-1:0] pat_b(input int k);
        return 32'h5C00_0000 ^ (32'(k) * 32'h0303_0007);
    endfunction

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_rd(output logic [DW-1:0] d);
        @(negedge clk) rd = 1'b1;
        @(negedge clk) rd = 1'b0;
        d = rdata;
    endtask

    task automatic do_wr(input logic [DW-1:0] d);
        @(negedge clk) begin wr = 1'b1; wdata = d; end
        @(negedge clk) wr = 1'b0;
    endtask

    task automatic set_lock(input logic v);
        @(negedge clk) lock = v;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic check_bank(input string req, input int lo, input int hi, input bit use_b);
        for (int k = lo; k < hi; k++) check(req, bank[k], use_b ? pat_b(k) : pat_a(k));
    endtask

    initial begin
        #300000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int k = 0; k < NREG; k++) bank[k] = pat_a(k);
        repeat (3) @(negedge clk);
        check("R1 rdata", rdata, '0);
        check("R1 err", 32'(err), 0);
        check("R1 we", 32'(we), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: unlocked access
        do_rd(got); check("R2 unlocked read", got, '0);
        do_wr(32'hDEAD_BEEF);
        check_bank("R2 unlocked write", 0, NREG, 1'b0);

        // R2/R3: locked but powered down, then count
        set_lock(1'b1);
        pwr = 1'b0;
        do_rd(got); check("R2 powered-down read", got, '0);
        do_wr(32'h1234_5678);
        check_bank("R2 powered-down write", 0, NREG, 1'b0);
        pwr = 1'b1;
        do_rd(got); check("R3 count", got, 32'(NREG));

        // R4/R6 save with tx full, rx empty; power dip mid-stream
        txf = 1'b1; rxf = 1'b0;
        for (int k = 0; k < NREG; k++) begin
            if (k == 5) begin
                pwr = 1'b0;
                do_rd(got); check("R2 dip read", got, '0);
                pwr = 1'b1;
            end
            do_rd(got);
            if (k == NREG - 1) check("R6 rx empty", got, '0);
            else check("R4 save slot", got, pat_a(k));
        end
        check("R8 no err before overrun", 32'(err), 0);
        do_rd(got); check("R8 overrun read", got, '0);
        check("R8 overrun err", 32'(err), 1);

        // R10 relock
        set_lock(1'b0);
        check("R10 err held while unlocked", 32'(err), 1);
        set_lock(1'b1);
        check("R10 err cleared", 32'(err), 0);
        do_rd(got); check("R10 count again", got, 32'(NREG));

        // R5 restore
        for (int k = 0; k < NREG; k++) begin
            @(negedge clk) begin wr = 1'b1; wdata = pat_b(k); end
            #1 check("R5 one-hot we", 32'(we), 32'(1) << k);
            @(negedge clk) wr = 1'b0;
        end
        check_bank("R5 restored", 0, NREG, 1'b1);
        do_wr(32'hFFFF_0000);
        check("R8 overrun write err", 32'(err), 1);
        check_bank("R8 overrun write ignored", 0, NREG, 1'b1);
        set_lock(1'b0);
        check("R9 no err after complete", 32'(err), 1);

        // R7 mixed direction
        for (int k = 0; k < NREG; k++) bank[k] = pat_a(k);
        txf = 1'b0; rxf = 1'b1;
        set_lock(1'b1);
        do_rd(got); check("R3 count", got, 32'(NREG));
        for (int k = 0; k < 3; k++) begin
            do_rd(got); check("R4 save slot", got, pat_a(k));
        end
        do_wr(32'h0BAD_0BAD);
        check("R7 mixed err", 32'(err), 1);
        check_bank("R7 mixed write ignored", 0, NREG, 1'b0);
        do_rd(got); check("R7 frozen read", got, '0);

        // R9 lock drop mid restore
        set_lock(1'b0);
        set_lock(1'b1);
        do_rd(got); check("R3 count", got, 32'(NREG));
        for (int k = 0; k < 5; k++) do_wr(pat_b(k));
        check("R9 no err yet", 32'(err), 0);
        set_lock(1'b0);
        check("R9 drop during restore err", 32'(err), 1);
        check_bank("R9 written slots", 0, 5, 1'b1);
        check_bank("R9 untouched slots", 5, NREG, 1'b0);

        // R9 drop during save: no error; R6 tx empty / rx full sweep
        for (int k = 0; k < NREG; k++) bank[k] = pat_a(k);
        set_lock(1'b1);
        check("R10 err cleared", 32'(err), 0);
        do_rd(got); check("R3 count", got, 32'(NREG));
        for (int k = 0; k < NREG; k++) begin
            do_rd(got);
            if (k == NREG - 2) check("R6 tx empty", got, '0);
            else check("R6 save slot", got, pat_a(k));
        end
        set_lock(1'b0);
        check("R9 drop after save no err", 32'(err), 0);
        set_lock(1'b1);
        do_rd(got);
        do_rd(got); do_rd(got);
        set_lock(1'b0);
        check("R9 drop during save no err", 32'(err), 0);

        // R11 write before count
        set_lock(1'b1);
        do_wr(32'h7777_7777);
        check("R11 early write err", 32'(err), 1);
        check_bank("R11 early write ignored", 0, NREG, 1'b0);
        do_rd(got); check("R11 no count after fault", got, '0);

        // R7 simultaneous read and write
        set_lock(1'b0);
        set_lock(1'b1);
        do_rd(got); check("R3 count", got, 32'(NREG));
        @(negedge clk) begin rd = 1'b1; wr = 1'b1; wdata = 32'h3333_3333; end
        @(negedge clk) begin rd = 1'b0; wr = 1'b0; end
        check("R7 both strobes err", 32'(err), 1);
        check("R7 both strobes read", rdata, '0);
        check_bank("R7 both strobes no write", 0, NREG, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule